// File: doc/BRIEF.md
# Masked Address Comparator

This block decides whether an address on a system bus belongs to the local node. It holds two programmable 8-bit values, a compare pattern and a bit-enable mask. Both are loaded from the local data bus through a strobe whose rising edge captures the data. A select line decides which of the two values a strobe writes. A qualifier input must be high for any write to take place.

On every clock the comparator checks the incoming bus address against the pattern, using only the bit positions the mask enables. It drives an active-low hit output one clock later. Loading a new pattern always clears the mask. Matching therefore stays off until software has programmed a fresh mask, so a half-finished reconfiguration cannot produce a false hit.

Top module: `addr_match_unit`

## Requirements
- R1: After reset the compare pattern and the mask are both zero, and `match_n` is high.
- R2: When the mask is non-zero and every address bit whose mask bit is 1 equals the matching pattern bit, `match_n` is low one clock after the address is presented. Otherwise it is high.
- R3: An address bit whose mask bit is 0 has no effect on `match_n`.
- R4: While the mask is all zeros, `match_n` stays high for every address.
- R5: A rising edge of `cfg_strobe` with `cfg_sel_cmp`=1 and `cfg_qual`=1 loads `cfg_wdata` into the compare pattern.
- R6: A rising edge of `cfg_strobe` with `cfg_sel_cmp`=0 and `cfg_qual`=1 loads `cfg_wdata` into the mask and leaves the compare pattern unchanged.
- R7: Every write to the compare pattern also clears the mask to all zeros.
- R8: A rising edge of `cfg_strobe` while `cfg_qual`=0 changes neither the pattern nor the mask.
- R9: Data is captured only on the clock where `cfg_strobe` is first seen high. Data changes while the strobe stays high are ignored. A strobe already high when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strobe | input | 1 | Write strobe; the rising edge captures data |
| cfg_sel_cmp | input | 1 | 1 selects the compare pattern, 0 selects the mask |
| cfg_qual | input | 1 | Write qualifier; writes happen only while high |
| cfg_wdata | input | ADDR_W | Local data bus carrying the register value |
| bus_addr | input | ADDR_W | Address under test |
| match_n | output | 1 | Active-low hit, registered |

## Verification
All 256 addresses are swept under several configurations:
- A cleared mask, which tells a disabled comparator apart from a matching one.
- A full mask, under which exactly one address may hit.
- Partial masks (high nibble, a single low bit), under which the hit set must grow to exactly the addresses that agree on the enabled bits. This shows that excluded bits are ignored.

After the sweeps, a compare-pattern write that must wipe a live mask is checked, along with an unqualified write and a strobe held high while its data changes. Each is checked through a further sweep, so that the effect on the hidden registers is seen at the hit output.

// File: rtl/amu_pkg.sv
package amu_pkg;
   // Choice of reduction structure for the equality check
   typedef enum logic {
      AMU_RED_FLAT   = 1'b0,
      AMU_RED_SLICED = 1'b1
   } amu_reduce_e;
endpackage

// File: rtl/amu_strobe_edge.sv
module amu_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic rise_o
);
   logic prev_q;

   // Reset to 1 so that a strobe held high across reset release is no edge
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= strobe_i;
   end

   assign rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/amu_cfg_regs.sv
module amu_cfg_regs #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic         sel_cmp_i,
   input  logic         qual_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] cmp_o,
   output logic [W-1:0] mask_o
);
   logic do_wr;
   assign do_wr = wr_i & qual_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_o  <= '0;
         mask_o <= '0;
      end else if (do_wr) begin
         if (sel_cmp_i) begin
            cmp_o  <= wdata_i;
            mask_o <= '0;      // new pattern disarms matching
         end else begin
            mask_o <= wdata_i;
         end
      end
   end
endmodule

// File: rtl/amu_cmp_core.sv
module amu_cmp_core #(
   parameter int                   W       = 8,
   parameter int                   SLICE_W = 4,
   parameter amu_pkg::amu_reduce_e REDUCE  = amu_pkg::AMU_RED_SLICED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] addr_i,
   input  logic [W-1:0] cmp_i,
   input  logic [W-1:0] mask_i,
   output logic         match_n_o
);
   localparam int NSLICE = (W + SLICE_W - 1) / SLICE_W;
   localparam int PAD_W  = NSLICE * SLICE_W;

   logic [W-1:0] diff;
   logic         hit;

   assign diff = (addr_i ^ cmp_i) & mask_i;

   generate
      if (REDUCE == amu_pkg::AMU_RED_FLAT) begin : g_flat
         assign hit = (diff == '0) && (|mask_i);
      end else begin : g_sliced
         logic [PAD_W-1:0]  diff_pad;
         logic [PAD_W-1:0]  mask_pad;
         logic [NSLICE-1:0] slice_clean;
         logic [NSLICE-1:0] slice_live;

         always_comb begin
            diff_pad = '0;
            mask_pad = '0;
            diff_pad[W-1:0] = diff;
            mask_pad[W-1:0] = mask_i;
         end

         for (genvar s = 0; s < NSLICE; s++) begin : g_slice
            assign slice_clean[s] = ~|diff_pad[s*SLICE_W +: SLICE_W];
            assign slice_live[s]  = |mask_pad[s*SLICE_W +: SLICE_W];
         end

         assign hit = (&slice_clean) & (|slice_live);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) match_n_o <= 1'b1;
      else        match_n_o <= ~hit;
   end
endmodule

// File: rtl/addr_match_unit.sv
module addr_match_unit #(
   parameter int                   ADDR_W  = 8,
   parameter int                   SLICE_W = 4,
   parameter amu_pkg::amu_reduce_e REDUCE  = amu_pkg::AMU_RED_SLICED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_strobe,
   input  logic              cfg_sel_cmp,
   input  logic              cfg_qual,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              match_n
);
   initial begin
      if (ADDR_W < 1)  $fatal(1, "addr_match_unit: ADDR_W must be at least 1");
      if (SLICE_W < 1) $fatal(1, "addr_match_unit: SLICE_W must be at least 1");
      if (SLICE_W > ADDR_W) $fatal(1, "addr_match_unit: SLICE_W exceeds ADDR_W");
   end

   logic              wr_rise;
   logic [ADDR_W-1:0] cmp_q;
   logic [ADDR_W-1:0] mask_q;

   amu_strobe_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (cfg_strobe),
      .rise_o   (wr_rise)
   );

   amu_cfg_regs #(.W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_rise),
      .sel_cmp_i (cfg_sel_cmp),
      .qual_i    (cfg_qual),
      .wdata_i   (cfg_wdata),
      .cmp_o     (cmp_q),
      .mask_o    (mask_q)
   );

   amu_cmp_core #(.W(ADDR_W), .SLICE_W(SLICE_W), .REDUCE(REDUCE)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (bus_addr),
      .cmp_i     (cmp_q),
      .mask_i    (mask_q),
      .match_n_o (match_n)
   );
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cfg_strobe,
   input logic         cfg_sel_cmp,
   input logic         cfg_qual,
   input logic [W-1:0] cfg_wdata,
   input logic [W-1:0] bus_addr,
   input logic [W-1:0] cmp_q,
   input logic [W-1:0] mask_q,
   input logic         match_n
);
   // Independent edge tracker, held high through reset
   logic seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= 1'b1;
      else        seen_q <= cfg_strobe;
   end
   logic edge_now;
   assign edge_now = cfg_strobe & ~seen_q;

   AST_EMPTY_MASK_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |=> match_n); // R4

   AST_HIT_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (match_n == !(($past(mask_q) != '0) &&
                (((($past(bus_addr) ^ $past(cmp_q)) & $past(mask_q))) == '0)))); // R2

   AST_PATTERN_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_now && cfg_qual && cfg_sel_cmp) |=>
         (cmp_q == $past(cfg_wdata)) && (mask_q == '0)); // R7

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_now && cfg_qual && !cfg_sel_cmp) |=>
         (mask_q == $past(cfg_wdata)) && $stable(cmp_q)); // R6

   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(edge_now && cfg_qual) |=> $stable(cmp_q) && $stable(mask_q)); // R8
endmodule

bind addr_match_unit amu_checker #(.W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_strobe  (cfg_strobe),
   .cfg_sel_cmp (cfg_sel_cmp),
   .cfg_qual    (cfg_qual),
   .cfg_wdata   (cfg_wdata),
   .bus_addr    (bus_addr),
   .cmp_q       (cmp_q),
   .mask_q      (mask_q),
   .match_n     (match_n)
);

// File: tb/addr_match_unit_tb_top.sv
module addr_match_unit_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_strobe = 1'b0;
   logic         cfg_sel_cmp = 1'b0;
   logic         cfg_qual = 1'b0;
   logic [W-1:0] cfg_wdata = '0;
   logic [W-1:0] bus_addr = '0;
   logic         match_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [W-1:0] m_cmp = '0;
   logic [W-1:0] m_mask = '0;

   always #4 clk = ~clk;   // 125 MHz

   addr_match_unit #(.ADDR_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_strobe(cfg_strobe), .cfg_sel_cmp(cfg_sel_cmp),
      .cfg_qual(cfg_qual), .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .match_n(match_n)
   );

   // Expected output computed bit by bit from the requirement text
   function automatic logic exp_match_n(logic [W-1:0] a, logic [W-1:0] c, logic [W-1:0] m);
      int enabled = 0;
      int agree = 0;
      for (int b = 0; b < W; b++) begin
         if (m[b]) begin
            enabled++;
            if (a[b] == c[b]) agree++;
         end
      end
      return !((enabled > 0) && (agree == enabled));
   endfunction

   task automatic check(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: match_n=%0b expected %0b (addr=%02h)", req, act, exp, bus_addr);
      end
   endtask

   task automatic sweep(string req);
      for (int a = 0; a < (1 << W); a++) begin
         @(negedge clk);
         bus_addr = a[W-1:0];
         @(negedge clk);
         check(req, match_n, exp_match_n(a[W-1:0], m_cmp, m_mask));
      end
   endtask

   task automatic write_reg(logic sel, logic qual, logic [W-1:0] d);
      @(negedge clk);
      cfg_sel_cmp = sel; cfg_qual = qual; cfg_wdata = d; cfg_strobe = 1'b1;
      @(negedge clk);
      cfg_strobe = 1'b0;
      if (qual) begin
         if (sel) begin m_cmp = d; m_mask = '0; end
         else     m_mask = d;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", match_n, 1'b1);
      sweep("R1");                           // reset state: zero mask
      write_reg(1'b1, 1'b1, 8'hA5);
      sweep("R4");                           // pattern only, mask empty
      write_reg(1'b0, 1'b1, 8'hFF);
      sweep("R2");                           // exact match only at A5
      write_reg(1'b0, 1'b1, 8'hF0);
      sweep("R3");                           // low nibble ignored
      write_reg(1'b0, 1'b1, 8'h01);
      sweep("R6");                           // mask write kept pattern
      write_reg(1'b1, 1'b1, 8'h3C);
      sweep("R7");                           // pattern write cleared live mask
      write_reg(1'b0, 1'b1, 8'hFF);
      sweep("R5");                           // new pattern 3C in effect
      write_reg(1'b1, 1'b0, 8'h00);
      write_reg(1'b0, 1'b0, 8'h00);
      sweep("R8");                           // unqualified writes ignored
      // R9: strobe held high, data changes after capture edge
      @(negedge clk);
      cfg_sel_cmp = 1'b0; cfg_qual = 1'b1; cfg_wdata = 8'h0F; cfg_strobe = 1'b1;
      repeat (2) @(negedge clk);
      cfg_wdata = 8'hF0;
      repeat (3) @(negedge clk);
      cfg_strobe = 1'b0;
      m_mask = 8'h0F;
      sweep("R9");
      // R9: strobe high across reset release is not an edge
      @(negedge clk);
      rst_n = 1'b0; cfg_strobe = 1'b1; cfg_sel_cmp = 1'b0; cfg_wdata = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_cmp = '0; m_mask = '0;
      repeat (3) @(negedge clk);
      cfg_strobe = 1'b0;
      sweep("R9");
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule